// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write Protector

This block sits between a processor's active-low chip enable and two external SRAM banks. While supply power is valid it passes the enable to one of two conditioned active-low outputs, chosen by a bank-select bit. The unselected output is held inactive. A separate circuit senses the supply voltage and presents the result to this block as a single synchronous "power good" flag.

When that flag drops, the block stops any new access from starting. An access that is already in progress may run to its end, but only until a write-protect timeout expires. After that both outputs are forced inactive and the system reset output is asserted. When power returns, both outputs stay inactive and reset stays asserted for a long recovery interval. Accesses are permitted again only when reset releases.

All delays are counted in microsecond ticks, which are derived from the clock by a prescaler. A dip in power during the recovery interval restarts that interval from the beginning.

Top module: `pf_ce_guard`

## Requirements
- R1: While running with power good and `ce_n` high, both `ce1_n` and `ce2_n` are high.
- R2: While running with power good and `ce_n` low, `ce1_n` is low when `bank_sel` is 0, and `ce2_n` is low when `bank_sel` is 1. The other output stays high, so the two outputs are never low together.
- R3: If `pwr_ok` falls while `ce_n` is high, both outputs are high from the next clock on, whatever `ce_n` does afterwards.
- R4: If `pwr_ok` falls while `ce_n` is low, the selected output keeps following `ce_n` until `ce_n` rises. During that drain, a change of `bank_sel` has no effect.
- R5: After power fails, once an output has gone high it is not driven low again until reset releases. A new `ce_n` falling edge never opens a cycle.
- R6: If the drained cycle has not ended after `WPT_TICKS*TICK_CYC` clocks, both outputs are forced high on the following clock.
- R7: `sys_rst_n` goes low no later than the clock on which both outputs are forced high. It goes low on the first clock after the fall of `pwr_ok` when no cycle is active.
- R8: Once `pwr_ok` returns, `sys_rst_n` stays low and both outputs stay high for `REC_TICKS*TICK_CYC` clocks. `sys_rst_n` then rises two clocks after that count.
- R9: A fall of `pwr_ok` during the recovery interval restarts the full recovery interval once power returns.
- R10: While `rst_n` is low and after it releases, `sys_rst_n` is low and both outputs are high, regardless of `ce_n`, until the recovery interval has elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `TICK_CYC` cycles make one microsecond tick |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | 1 while supply is within tolerance (synchronous flag) |
| ce_n | input | 1 | Processor chip enable, active low |
| bank_sel | input | 1 | Bank choice: 0 steers to `ce1_n`, 1 to `ce2_n` |
| ce1_n | output | 1 | Conditioned chip enable for bank 1, active low |
| ce2_n | output | 1 | Conditioned chip enable for bank 2, active low |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The bench builds the block with `TICK_CYC`=4, `WPT_TICKS`=10 and `REC_TICKS`=50. This shrinks the write-protect window to 40 clocks and the recovery interval to 200 clocks. With these values, the exact clock on which the drain timeout fires and the exact clock on which reset releases can both be probed, one clock before and one clock after. A recovery that is interrupted and restarted can also be run several times within a short run.

// File: rtl/pfg_pkg.sv
// Shared types for the power-fail chip-enable guard.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pfg_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,  // recovery wait, reset asserted
        ST_RUN   = 2'd1,  // normal pass-through
        ST_DRAIN = 2'd2,  // power lost, in-flight cycle may finish
        ST_LOCK  = 2'd3   // power lost, all outputs inactive
    } pfg_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/pfg_timer.sv
// Tick-based interval timer: a prescaler makes one tick every TICK_CYC
// clocks, and a tick counter saturates at the limit given on lim.
// Assumes clr is pulsed on every state change; clr restarts both the
// prescaler and the counter, so intervals are exact in clocks.
module pfg_timer #(
    parameter int TICK_CYC = 250,
    parameter int CW       = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] lim,
    output logic          done
);
    localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYC - 1);

    logic [PW-1:0] pre_q;
    logic [CW-1:0] cnt_q;

    // Advance the prescaler and count whole ticks up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            if (cnt_q < lim) cnt_q <= cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Interval complete once the count reaches the limit.
    always_comb done = (cnt_q >= lim);
endmodule

// File: rtl/pfg_fsm.sv
// Sequencer for the guard: recovery hold, run, drain and lock states.
// Captures the bank of the access in flight when power fails and picks
// the timer limit for the current state.
// Assumes pwr_ok is already synchronous to clk.
module pfg_fsm
    import pfg_pkg::*;
#(
    parameter int WPT_TICKS = 100,
    parameter int REC_TICKS = 80000,
    parameter int CW        = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          ce_n,
    input  logic          bank_sel,
    input  logic          tmr_done,
    output pfg_state_e    state,
    output logic          bank_q,
    output logic          tmr_clr,
    output logic [CW-1:0] tmr_lim
);
    pfg_state_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (!pwr_ok) state_d = ST_LOCK;
                      else if (tmr_done) state_d = ST_RUN;
            ST_RUN:   if (!pwr_ok) state_d = ce_n ? ST_LOCK : ST_DRAIN;
            ST_DRAIN: if (ce_n || tmr_done) state_d = ST_LOCK;
            ST_LOCK:  if (pwr_ok) state_d = ST_HOLD;
            default:  state_d = ST_LOCK;
        endcase
    end

    // State register; reset starts in the recovery hold.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Track bank choice while running; frozen during drain.
    always_ff @(posedge clk) begin
        if (!rst_n)                bank_q <= 1'b0;
        else if (state_q == ST_RUN) bank_q <= bank_sel;
    end

    // Timer restarts on every transition; limit follows the state.
    always_comb begin
        tmr_clr = (state_d != state_q);
        tmr_lim = (state_q == ST_HOLD) ? CW'(REC_TICKS) : CW'(WPT_TICKS);
    end

    assign state = state_q;
endmodule

// File: rtl/pfg_steer.sv
// Output stage: decodes the enable onto one of two banks when access is
// allowed, otherwise holds both inactive; derives the system reset.
// Assumes bank_q holds the bank of the in-flight access during drain.
module pfg_steer
    import pfg_pkg::*;
(
    input  pfg_state_e state,
    input  logic       ce_n,
    input  logic       bank_sel,
    input  logic       bank_q,
    output logic       ce1_n,
    output logic       ce2_n,
    output logic       sys_rst_n
);
    logic en;
    logic bank;

    // Gate and decode the processor enable.
    always_comb begin
        en        = (state == ST_RUN) || (state == ST_DRAIN);
        bank      = (state == ST_DRAIN) ? bank_q : bank_sel;
        ce1_n     = ce_n | ~en | bank;
        ce2_n     = ce_n | ~en | ~bank;
        sys_rst_n = en;
    end
endmodule

// File: rtl/pf_ce_guard.sv
// Power-fail chip-enable write protector (top level).
// Steers an active-low enable to two banks while power is good. It lets an
// in-flight cycle finish under a timeout on power loss and holds reset
// through a recovery interval. Assumes pwr_ok is synchronous to clk and
// that TICK_CYC clocks make one microsecond.
module pf_ce_guard
    import pfg_pkg::*;
#(
    parameter int TICK_CYC  = 250,
    parameter int WPT_TICKS = 100,
    parameter int REC_TICKS = 80000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic ce_n,
    input  logic bank_sel,
    output logic ce1_n,
    output logic ce2_n,
    output logic sys_rst_n
);
    localparam int CNT_MAX = imax(WPT_TICKS, REC_TICKS);
    localparam int CW      = $clog2(CNT_MAX + 1);

    pfg_state_e    state;
    logic          bank_q;
    logic          tmr_clr;
    logic          tmr_done;
    logic [CW-1:0] tmr_lim;

    pfg_fsm #(
        .WPT_TICKS (WPT_TICKS),
        .REC_TICKS (REC_TICKS),
        .CW        (CW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_ok   (pwr_ok),
        .ce_n     (ce_n),
        .bank_sel (bank_sel),
        .tmr_done (tmr_done),
        .state    (state),
        .bank_q   (bank_q),
        .tmr_clr  (tmr_clr),
        .tmr_lim  (tmr_lim)
    );

    pfg_timer #(
        .TICK_CYC (TICK_CYC),
        .CW       (CW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .lim   (tmr_lim),
        .done  (tmr_done)
    );

    pfg_steer u_steer (
        .state     (state),
        .ce_n      (ce_n),
        .bank_sel  (bank_sel),
        .bank_q    (bank_q),
        .ce1_n     (ce1_n),
        .ce2_n     (ce2_n),
        .sys_rst_n (sys_rst_n)
    );
endmodule

// File: rtl/pf_ce_guard_chk.sv
// Checker for pf_ce_guard: port-level properties, with cycle counters for
// the parameter-sized windows. Attached by bind below.
module pf_ce_guard_chk #(
    parameter int TICK_CYC  = 250,
    parameter int WPT_TICKS = 100,
    parameter int REC_TICKS = 80000
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok,
    input logic ce_n,
    input logic bank_sel,
    input logic ce1_n,
    input logic ce2_n,
    input logic sys_rst_n
);
    localparam logic [31:0] DRAIN_MAX = 32'(WPT_TICKS * TICK_CYC + 2);
    localparam logic [31:0] REC_MIN   = 32'(REC_TICKS * TICK_CYC);

    logic [31:0] ok_run;
    logic [31:0] low_run;

    // Consecutive clocks with power good (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok)  ok_run <= '0;
        else if (ok_run != '1)  ok_run <= ok_run + 1'b1;
    end

    // Consecutive clocks with power bad and some output active.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_ok || (ce1_n && ce2_n)) low_run <= '0;
        else                                     low_run <= low_run + 1'b1;
    end

    // R2
    one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ce1_n, ~ce2_n}));

    // R8
    rst_gates_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> (ce1_n && ce2_n));

    // R5
    no_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_ok && $past(!pwr_ok) && $past(ce1_n) && $past(ce2_n))
            |-> (ce1_n && ce2_n));

    // R7
    rst_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_ok && ce1_n && ce2_n) |=> !sys_rst_n);

    // R6
    drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= DRAIN_MAX);

    // R8
    rec_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (ok_run >= REC_MIN));
endmodule

bind pf_ce_guard pf_ce_guard_chk #(
    .TICK_CYC  (TICK_CYC),
    .WPT_TICKS (WPT_TICKS),
    .REC_TICKS (REC_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ok    (pwr_ok),
    .ce_n      (ce_n),
    .bank_sel  (bank_sel),
    .ce1_n     (ce1_n),
    .ce2_n     (ce2_n),
    .sys_rst_n (sys_rst_n)
);

// File: tb/pf_ce_guard_tb.sv
// Directed bench for pf_ce_guard; one task per scenario.
module pf_ce_guard_tb;
    localparam int TICK_CYC  = 4;
    localparam int WPT_TICKS = 10;
    localparam int REC_TICKS = 50;
    localparam int WPT_CYC   = WPT_TICKS * TICK_CYC;
    localparam int REC_CYC   = REC_TICKS * TICK_CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1;
    logic ce_n = 1'b1;
    logic bank_sel = 1'b0;
    logic ce1_n, ce2_n, sys_rst_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pf_ce_guard #(
        .TICK_CYC  (TICK_CYC),
        .WPT_TICKS (WPT_TICKS),
        .REC_TICKS (REC_TICKS)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .ce_n      (ce_n),
        .bank_sel  (bank_sel),
        .ce1_n     (ce1_n),
        .ce2_n     (ce2_n),
        .sys_rst_n (sys_rst_n)
    );

    // Observed vector: {sys_rst_n, ce2_n, ce1_n}
    task automatic expect_obs(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {sys_rst_n, ce2_n, ce1_n};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {rst,ce2,ce1} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bring power back with the bus idle and wait for release.
    task automatic restore_power();
        ce_n = 1'b1;
        pwr_ok = 1'b1;
        wait_neg(REC_CYC + 2);
    endtask

    task automatic t_reset();
        ce_n = 1'b0;
        wait_neg(5);
        expect_obs("R10 in reset", 3'b011);
        rst_n = 1'b1;
        wait_neg(REC_CYC - 5);
        expect_obs("R10 before recovery end", 3'b011);
        ce_n = 1'b1;
        wait_neg(8);
        expect_obs("R8 released after reset recovery", 3'b111);
    endtask

    task automatic t_steer();
        expect_obs("R1 idle", 3'b111);
        bank_sel = 1'b0; ce_n = 1'b0;
        wait_neg(1);
        expect_obs("R2 bank 0", 3'b110);
        bank_sel = 1'b1;
        wait_neg(1);
        expect_obs("R2 bank 1", 3'b101);
        ce_n = 1'b1;
        wait_neg(1);
        expect_obs("R1 idle after access", 3'b111);
    endtask

    task automatic t_fail_idle();
        ce_n = 1'b1;
        pwr_ok = 1'b0;
        wait_neg(1);
        expect_obs("R7 reset next clock when idle", 3'b011);
        ce_n = 1'b0; bank_sel = 1'b0;
        wait_neg(3);
        expect_obs("R3 outputs blocked after fail", 3'b011);
        restore_power();
        expect_obs("R8 release after restore", 3'b111);
    endtask

    task automatic t_fail_drain();
        bank_sel = 1'b1; ce_n = 1'b0;
        wait_neg(1);
        pwr_ok = 1'b0;
        wait_neg(3);
        expect_obs("R4 drain keeps bank 1 active", 3'b101);
        bank_sel = 1'b0;
        wait_neg(2);
        expect_obs("R4 bank_sel ignored in drain", 3'b101);
        ce_n = 1'b1;
        wait_neg(1);
        expect_obs("R4 cycle ends", 3'b011);
        ce_n = 1'b0;
        wait_neg(2);
        expect_obs("R5 new access refused", 3'b011);
        restore_power();
        expect_obs("R8 release after drain", 3'b111);
    endtask

    task automatic t_drain_timeout();
        bank_sel = 1'b0; ce_n = 1'b0;
        wait_neg(1);
        pwr_ok = 1'b0;
        wait_neg(WPT_CYC + 1);
        expect_obs("R6 still draining at limit", 3'b110);
        wait_neg(1);
        expect_obs("R6 forced inactive after timeout", 3'b011);
        restore_power();
        expect_obs("R8 release after timeout", 3'b111);
    endtask

    task automatic t_recovery_len();
        pwr_ok = 1'b0;
        wait_neg(3);
        ce_n = 1'b0;
        pwr_ok = 1'b1;
        wait_neg(REC_CYC + 1);
        expect_obs("R8 held one clock before end", 3'b011);
        wait_neg(1);
        expect_obs("R8 released at end", 3'b110);
        ce_n = 1'b1;
        wait_neg(1);
    endtask

    task automatic t_dip();
        pwr_ok = 1'b0;
        wait_neg(3);
        pwr_ok = 1'b1;
        wait_neg(REC_CYC / 2);
        pwr_ok = 1'b0;
        wait_neg(2);
        pwr_ok = 1'b1;
        wait_neg(REC_CYC + 1);
        expect_obs("R9 full interval after dip", 3'b011);
        wait_neg(1);
        expect_obs("R9 release after restarted interval", 3'b111);
    endtask

    initial begin
        wait_neg(1);
        t_reset();
        t_steer();
        t_fail_idle();
        t_fail_drain();
        t_drain_timeout();
        t_recovery_len();
        t_dip();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule